// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is a synchronous master for an external bus on which the address and the data share one set of lines. A single internal request carries an address, write data, a direction bit, a memory-space bit and an extended-timing bit. The block turns that request into a bus cycle built from whole clock periods. The address is placed on the shared lines and captured externally by the rising edge of an active-low address strobe. The lines are then released, or turned over to write data. An active-low data strobe frames the data transfer. For a read, the rising edge of that data strobe also samples the incoming data.

An active-low direction line (low means write) and an active-low space select (low means the data-memory space) stay stable across the whole cycle. The drive enable of the shared lines is never asserted while an external device may be returning read data. A ready/valid handshake admits one request at a time. When the cycle has finished, a one-clock done pulse is given with the read data. Extended timing lengthens the data-strobe low phase by a parameterised number of clocks. It is sampled only when a request is accepted.

Top module: `mux_bus_ctrl`

## Requirements
- R1: While rstN is low: asN, dsN, rwN and dmN are high, busOe and rspDone are low, and reqReady is high.
- R2: A request is accepted on a clock edge where reqValid and reqReady are both high. The clock after acceptance is a setup clock: the address is driven on busOut with busOe high, and asN is still high. asN is then low for AS_LOW_CYC clocks, and the address stays driven for ADDR_HOLD_CYC clocks after asN rises.
- R3: For a write, busOe is high and busOut carries the write data, zero-extended, from the clock after the address hold through the clock after dsN rises.
- R4: Without extended timing, dsN is low for DS_RD_CYC clocks on a read and DS_WR_CYC clocks on a write. For a read, there is exactly one clock with busOe low between the address hold and dsN falling.
- R5: When extTiming is high at acceptance, dsN stays low EXT_CYC clocks longer. A change of extTiming during a cycle has no effect on that cycle.
- R6: For a read, busIn is sampled on the clock edge at which dsN rises, and the value appears on rspRdata. rspDone is high for exactly the one clock following that edge, on reads and on writes alike.
- R7: busOe is low throughout a read's data-strobe phase, in the done clock and the RECOVER_CYC recovery clocks that follow, and while idle.
- R8: rwN equals the inverse of the accepted reqWrite, and dmN equals the inverse of the accepted reqDataSpace. Both hold from the setup clock through the recovery clocks and do not change while dsN is low or in the clock after it rises. Both are high when idle.
- R9: reqReady is high only when no cycle is in progress. A request presented while busy is ignored, and at least one recovery clock with asN high follows every rise of dsN.
- R10: asN and dsN are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request can be accepted |
| reqAddr | input | ADDR_W | Cycle address |
| reqWdata | input | DATA_W | Write data |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| reqDataSpace | input | 1 | 1 = data-memory space |
| extTiming | input | 1 | 1 = stretch the data-strobe phase |
| rspDone | output | 1 | One-clock cycle completion pulse |
| rspRdata | output | DATA_W | Read data captured at data-strobe rise |
| busOut | output | BUS_W | Value driven onto the shared lines |
| busOe | output | 1 | Drive enable of the shared lines |
| busIn | input | DATA_W | Data lanes of the shared lines as seen from outside |
| asN | output | 1 | Address strobe, active low |
| dsN | output | 1 | Data strobe, active low |
| rwN | output | 1 | Direction, low = write |
| dmN | output | 1 | Space select, low = data memory |

## Verification
The bench models the external device with a decoy value on busIn that changes to the real read data only for the edge at which dsN rises. A controller that samples one clock early or one clock late returns the decoy. Each cycle is traced clock by clock against a phase model, so an off-by-one strobe width, a missing float clock, or a stretch that ignores the direction would show up as a strobe or enable mismatch at the wrong offset. Some requests toggle extTiming mid-cycle, and some hold reqValid high with conflicting fields while the controller is busy. A design that re-samples the stretch setting or accepts early would then produce a wrong length, a wrong address or a ready at the wrong time. Read data of all-zero and all-one also exposes a bus that is driven during the read phase.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ADDR,
    ST_ADDR_HOLD,
    ST_FLOAT,
    ST_DS_ACTIVE,
    ST_DS_END,
    ST_RECOVER
  } busState_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchReq;   // capture request fields this edge
    logic driveAddr;  // address on the shared lines
    logic driveData;  // write data on the shared lines
    logic capture;    // sample read data this edge
    logic done;       // completion clock
    logic inCycle;    // a cycle is in progress
  } busStrobe_t;

endpackage

// File: rtl/mbc_control.sv
module mbc_control
  import mbc_pkg::*;
#(
  parameter int AS_LOW_CYC    = 1,
  parameter int ADDR_HOLD_CYC = 1,
  parameter int DS_RD_CYC     = 4,
  parameter int DS_WR_CYC     = 2,
  parameter int EXT_CYC       = 2,
  parameter int RECOVER_CYC   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       extTiming,
  output logic       reqReady,
  output logic       asN,
  output logic       dsN,
  output busStrobe_t strobes
);

  localparam int MAX_DS  = ((DS_RD_CYC > DS_WR_CYC) ? DS_RD_CYC : DS_WR_CYC) + EXT_CYC;
  localparam int MAX_PH  = MAX_DS + AS_LOW_CYC + ADDR_HOLD_CYC + RECOVER_CYC;
  localparam int CNT_W   = $clog2(MAX_PH + 1);

  busState_e        state;
  logic [CNT_W-1:0] phaseCnt;
  logic             wrQ;
  logic             extQ;
  logic [CNT_W-1:0] dsLen;
  logic             cntZero;

  always_comb begin
    dsLen = (wrQ ? CNT_W'(DS_WR_CYC) : CNT_W'(DS_RD_CYC))
          + (extQ ? CNT_W'(EXT_CYC) : CNT_W'(0));
  end

  assign cntZero = (phaseCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      wrQ      <= 1'b0;
      extQ     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            wrQ   <= reqWrite;
            extQ  <= extTiming;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          state    <= ST_ADDR;
          phaseCnt <= CNT_W'(AS_LOW_CYC - 1);
        end
        ST_ADDR: begin
          if (cntZero) begin
            state    <= ST_ADDR_HOLD;
            phaseCnt <= CNT_W'(ADDR_HOLD_CYC - 1);
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_ADDR_HOLD: begin
          if (cntZero) state <= ST_FLOAT;
          else         phaseCnt <= phaseCnt - 1'b1;
        end
        ST_FLOAT: begin
          state    <= ST_DS_ACTIVE;
          phaseCnt <= dsLen - 1'b1;
        end
        ST_DS_ACTIVE: begin
          if (cntZero) state <= ST_DS_END;
          else         phaseCnt <= phaseCnt - 1'b1;
        end
        ST_DS_END: begin
          state    <= ST_RECOVER;
          phaseCnt <= CNT_W'(RECOVER_CYC - 1);
        end
        ST_RECOVER: begin
          if (cntZero) state <= ST_IDLE;
          else         phaseCnt <= phaseCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady          = (state == ST_IDLE);
    asN               = (state != ST_ADDR);
    dsN               = (state != ST_DS_ACTIVE);
    strobes.latchReq  = (state == ST_IDLE) && reqValid;
    strobes.driveAddr = (state == ST_SETUP) || (state == ST_ADDR) || (state == ST_ADDR_HOLD);
    strobes.driveData = wrQ && ((state == ST_FLOAT) || (state == ST_DS_ACTIVE)
                                || (state == ST_DS_END));
    strobes.capture   = (state == ST_DS_ACTIVE) && cntZero && !wrQ;
    strobes.done      = (state == ST_DS_END);
    strobes.inCycle   = (state != ST_IDLE);
  end

  // R10: strobes never overlap
  assert_strobe_overlap_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(!asN && !dsN));

  // R6: completion is a single-clock pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.done |=> !strobes.done);

  // R9: address strobe stays high for a recovery gap after data strobe rises
  assert_recover_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dsN) |-> asN ##1 asN);

endmodule

// File: rtl/mbc_datapath.sv
module mbc_datapath
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqWrite,
  input  logic              reqDataSpace,
  input  logic [DATA_W-1:0] busIn,
  output logic [BUS_W-1:0]  busOut,
  output logic              busOe,
  output logic              rwN,
  output logic              dmN,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              writeQ;
  logic              spaceQ;
  logic [DATA_W-1:0] rdataQ;
  logic [BUS_W-1:0]  addrBus;
  logic [BUS_W-1:0]  wdataBus;

  generate
    if (BUS_W > DATA_W) begin : g_wpad
      assign wdataBus = {{(BUS_W-DATA_W){1'b0}}, wdataQ};
    end else begin : g_wfull
      assign wdataBus = wdataQ;
    end
    if (BUS_W > ADDR_W) begin : g_apad
      assign addrBus = {{(BUS_W-ADDR_W){1'b0}}, addrQ};
    end else begin : g_afull
      assign addrBus = addrQ;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
      spaceQ <= 1'b0;
      rdataQ <= '0;
    end else begin
      if (strobes.latchReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        writeQ <= reqWrite;
        spaceQ <= reqDataSpace;
      end
      if (strobes.capture) rdataQ <= busIn;
    end
  end

  always_comb begin
    busOe    = strobes.driveAddr || strobes.driveData;
    busOut   = strobes.driveAddr ? addrBus : (strobes.driveData ? wdataBus : '0);
    rwN      = strobes.inCycle ? ~writeQ : 1'b1;
    dmN      = strobes.inCycle ? ~spaceQ : 1'b1;
    rspRdata = rdataQ;
  end

  // R3: address and write data are never requested together
  assert_drive_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.driveAddr && strobes.driveData));

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int AS_LOW_CYC    = 1,
  parameter int ADDR_HOLD_CYC = 1,
  parameter int DS_RD_CYC     = 4,
  parameter int DS_WR_CYC     = 2,
  parameter int EXT_CYC       = 2,
  parameter int RECOVER_CYC   = 1,
  localparam int BUS_W        = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqWrite,
  input  logic              reqDataSpace,
  input  logic              extTiming,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic [BUS_W-1:0]  busOut,
  output logic              busOe,
  input  logic [DATA_W-1:0] busIn,
  output logic              asN,
  output logic              dsN,
  output logic              rwN,
  output logic              dmN
);

  busStrobe_t strobes;

  mbc_control #(
    .AS_LOW_CYC(AS_LOW_CYC), .ADDR_HOLD_CYC(ADDR_HOLD_CYC),
    .DS_RD_CYC(DS_RD_CYC), .DS_WR_CYC(DS_WR_CYC),
    .EXT_CYC(EXT_CYC), .RECOVER_CYC(RECOVER_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .extTiming(extTiming), .reqReady(reqReady), .asN(asN), .dsN(dsN),
    .strobes(strobes)
  );

  mbc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqWrite(reqWrite), .reqDataSpace(reqDataSpace),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .rwN(rwN), .dmN(dmN),
    .rspRdata(rspRdata)
  );

  assign rspDone = strobes.done;

  // R7: never drive against returning read data
  assert_read_float_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!dsN && rwN) |-> !busOe);

  // R2: address already on the lines the clock before the strobe falls
  assert_addr_setup_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(asN) |-> $past(busOe));

  // R8: direction and space hold across the data strobe and just after
  assert_rw_dm_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !dsN |=> ($stable(rwN) && $stable(dmN)));

endmodule

// File: tb/sim_mux_bus_ctrl.sv
module sim_mux_bus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AS_LOW = 1, HOLD = 1, DS_RD = 4, DS_WR = 2, EXT = 2, REC = 1;
  localparam int PH_IDLE = 0, PH_SETUP = 1, PH_ADDR = 2, PH_HOLD = 3,
                 PH_FLOAT = 4, PH_DS = 5, PH_DSEND = 6, PH_REC = 7;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, reqDataSpace = 0, extTiming = 0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0, busIn = '0;
  logic reqReady, rspDone, busOe, asN, dsN, rwN, dmN;
  logic [7:0]  rspRdata;
  logic [15:0] busOut;
  int checks = 0, fails = 0, cycleCnt = 0;

  mux_bus_ctrl #(.ADDR_W(16), .DATA_W(8), .AS_LOW_CYC(AS_LOW), .ADDR_HOLD_CYC(HOLD),
    .DS_RD_CYC(DS_RD), .DS_WR_CYC(DS_WR), .EXT_CYC(EXT), .RECOVER_CYC(REC)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqWrite(reqWrite),
    .reqDataSpace(reqDataSpace), .extTiming(extTiming), .rspDone(rspDone),
    .rspRdata(rspRdata), .busOut(busOut), .busOe(busOe), .busIn(busIn),
    .asN(asN), .dsN(dsN), .rwN(rwN), .dmN(dmN));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int dsLen(bit w, bit e);
    return (w ? DS_WR : DS_RD) + (e ? EXT : 0);
  endfunction

  function automatic int phaseAt(int k, bit w, bit e);
    int r = k;
    if (r == 1) return PH_SETUP;
    r -= 1;
    if (r <= AS_LOW) return PH_ADDR;
    r -= AS_LOW;
    if (r <= HOLD) return PH_HOLD;
    r -= HOLD;
    if (r == 1) return PH_FLOAT;
    r -= 1;
    if (r <= dsLen(w, e)) return PH_DS;
    r -= dsLen(w, e);
    if (r == 1) return PH_DSEND;
    r -= 1;
    if (r <= REC) return PH_REC;
    return PH_IDLE;
  endfunction

  // Starts and ends just after a falling edge
  task automatic runCycle(input logic [15:0] a, input logic [7:0] d, input bit w,
                          input bit s, input bit e, input logic [7:0] rd,
                          input bit busyPoke, input bit toggleExt);
    int total = 1 + AS_LOW + HOLD + 1 + dsLen(w, e) + 1 + REC;
    string dsTag = e ? "R5" : "R4";
    reqAddr = a; reqWdata = d; reqWrite = w; reqDataSpace = s; extTiming = e;
    reqValid = 1; busIn = ~rd;
    for (int k = 1; k <= total + 1; k++) begin
      int p;
      bit expOe;
      @(negedge clk);
      p = phaseAt(k, w, e);
      if (k == 1) begin
        reqValid = busyPoke;
        if (busyPoke) begin
          reqAddr = ~a; reqWrite = ~w; reqDataSpace = ~s; extTiming = ~e;
        end
      end
      if (toggleExt) extTiming = ~extTiming;
      chk(asN == (p != PH_ADDR), "R2 asN", asN, p != PH_ADDR);
      chk(dsN == (p != PH_DS), dsTag, dsN, p != PH_DS);
      chk(!(!asN && !dsN), "R10 overlap", {asN, dsN}, 3);
      expOe = (p == PH_SETUP || p == PH_ADDR || p == PH_HOLD) ? 1'b1
            : (p == PH_FLOAT || p == PH_DS || p == PH_DSEND) ? w : 1'b0;
      chk(busOe == expOe, w ? "R3 busOe" : "R7 busOe", busOe, expOe);
      if (expOe && (p == PH_SETUP || p == PH_ADDR || p == PH_HOLD))
        chk(busOut == a, "R2 address", busOut, a);
      else if (expOe)
        chk(busOut == {8'h00, d}, "R3 write data", busOut, {8'h00, d});
      if (p == PH_IDLE) begin
        chk(rwN == 1 && dmN == 1, "R8 idle lines", {rwN, dmN}, 3);
        chk(reqReady == 1, "R9 ready idle", reqReady, 1);
      end else begin
        chk(rwN == !w && dmN == !s, "R8 lines", {rwN, dmN}, {!w, !s});
        chk(reqReady == 0, "R9 busy", reqReady, 0);
      end
      chk(rspDone == (p == PH_DSEND), "R6 done", rspDone, p == PH_DSEND);
      if (p == PH_DSEND && !w) chk(rspRdata == rd, "R6 read data", rspRdata, rd);
      // busIn carries the real value only for the edge where dsN rises
      busIn = (p == PH_DS && phaseAt(k + 1, w, e) != PH_DS) ? rd : ~rd;
      if (busyPoke && k == total) reqValid = 0;
    end
    extTiming = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycleCnt++;
      if (cycleCnt > 150000) begin
        fails++;
        $display("FAIL watchdog R9 actual=%0d expected=<150000", cycleCnt);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk(asN && dsN && rwN && dmN, "R1 strobes", {asN, dsN, rwN, dmN}, 15);
    chk(!busOe && !rspDone, "R1 oe/done", {busOe, rspDone}, 0);
    chk(reqReady, "R1 ready", reqReady, 1);
    reqValid = 1;  // a request during reset
    @(negedge clk);
    chk(!busOe && asN, "R7 reset float", {busOe, asN}, 1);
    reqValid = 0;
    rstN = 1;
    @(negedge clk);
    // directed corners
    runCycle(16'h1234, 8'h00, 0, 0, 0, 8'hA5, 0, 0);
    runCycle(16'hBEEF, 8'h5A, 1, 1, 0, 8'h00, 0, 0);
    runCycle(16'h0001, 8'h00, 0, 1, 1, 8'hFF, 0, 0);
    runCycle(16'hFFFF, 8'hFF, 1, 0, 1, 8'h00, 0, 0);
    runCycle(16'h8000, 8'h00, 0, 0, 0, 8'h00, 1, 0);
    runCycle(16'h4321, 8'h81, 1, 1, 1, 8'h3C, 1, 0);
    runCycle(16'h2222, 8'h00, 0, 0, 0, 8'hC3, 0, 1);
    runCycle(16'h3333, 8'h77, 1, 0, 1, 8'h00, 0, 1);
    // constrained random
    for (int i = 0; i < 60; i++) begin
      runCycle(16'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), 8'($urandom), ($urandom % 4) == 0, ($urandom % 3) == 0);
    end
    // stays idle with no request
    repeat (3) begin
      @(negedge clk);
      chk(reqReady && asN && dsN && !busOe, "R9 stays idle",
          {reqReady, asN, dsN, busOe}, 14);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule